// File: doc/BRIEF.md
# Context-Switch Instruction Execution Unit

This unit sits beside the main datapath of a small stack processor and carries out the seven extra opcodes that a software scheduler needs to switch between processes. With these opcodes the scheduler can write values and prepared stack addresses into a process table, save and reload the stack pointer, branch when a status word in memory is zero, load two priorities into the ALU operand registers, and jump through a pointer in memory. The unit owns the SP, PC, A and B registers that these opcodes change. It reaches memory through a simple synchronous byte port.

The sequencer samples the start strobe together with the decoded opcode and two 16-bit operands. It then runs a fixed number of micro-steps that depends on the opcode and raises `done` in the last of them. The state machine has five states. In S_IDLE it waits for a start. S_LO makes the low-byte access and S_HI makes the high-byte access. S_TAIL captures the high read byte and then pads the instruction to its length. S_FINAL raises `done` and commits the registers. It takes these transitions:

- S_IDLE to S_LO, on a start whose opcode touches memory.
- S_IDLE to S_TAIL, on a start for the priority load.
- S_IDLE back to S_IDLE, on an illegal opcode.
- S_LO to S_HI, and S_HI to S_TAIL, each unconditionally.
- S_TAIL to S_FINAL, when the step count reaches one less than the opcode's length.
- S_FINAL to S_IDLE, unconditionally.

Top module: `ctxsw_exec_unit`

## Requirements
- R1: After reset, SP, PC, A and B are all 0x0000. The signals done, illegal, mem_rd and mem_wr are all low.
- R2: A start with a legal opcode is accepted at a clock edge, and the next cycle is micro-step 1. The signal done is high only in micro-step N. N is 9 for 0xF4, 9 for 0xF5, 11 for 0xF6, 7 for 0xF7, 12 for 0xF8, 11 for 0xF9 and 7 for 0xFA.
- R3: Opcode 0xF4 (store value) writes src1 to the word at address src2. The low byte goes to address src2 in step 1 and the high byte goes to address src2+1 in step 2.
- R4: Opcode 0xF5 (stack setup) writes src1 minus 2, modulo 2^16, to the word at address src2, with the same byte order and timing as R3.
- R5: Opcode 0xF7 (save stack pointer) writes the current SP to the word at address src1, low byte first at src1.
- R6: Opcode 0xF6 (reload stack pointer) sets SP to the word at address src1. The byte at src1 is the low byte and the byte at src1+1 is the high byte.
- R7: Opcode 0xF8 (branch on zero flag) reads the word at address src1. If the word is zero, PC becomes PC+src2 modulo 2^16. Otherwise PC becomes PC+1.
- R8: Opcode 0xF9 (priority load) sets A to src1 and B to src2 and makes no memory access.
- R9: Opcode 0xFA (indirect jump) sets PC to the word at address src1.
- R10: Register changes take effect at the clock edge that ends the done cycle. Registers an opcode does not name keep their values, and PC changes only under 0xF8 and 0xFA.
- R11: A start with an opcode outside 0xF4 to 0xFA drives illegal high for exactly the cycle after the accepting edge. It causes no memory access, no done and no register change.
- R12: A start that arrives while an instruction is in progress is ignored. This includes a start in the done cycle, and the operands of the running instruction are kept.
- R13: Read data on mem_rdata belongs to the address of the previous cycle's read. mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction, sampled only when idle |
| opcode | input | 8 | Decoded opcode |
| src1 | input | 16 | First register operand |
| src2 | input | 16 | Second register operand |
| mem_addr | output | 16 | Byte address |
| mem_rd | output | 1 | Read request; data returns the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after mem_rd |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |
| alu_a | output | 16 | ALU operand register A |
| alu_b | output | 16 | ALU operand register B |
| done | output | 1 | High in the final micro-step |
| illegal | output | 1 | One-cycle flag for an unknown opcode |

## Verification
The bench counts cycles from start to done for every opcode. A sequencer that pads wrongly would report one step early or late. For the branch it checks both a zero word and a nonzero word, and it makes the offset wrap past 0xFFFF. A design that swaps bytes or tests only one byte of the word would branch on a nonzero flag. Stack setup with src1 = 1 must store 0xFFFF, which catches a missing borrow. The bench drives start again in mid-instruction and again in the done cycle, with poisoned operands. A unit that restarts or relatches would produce a wrong length, a wrong result, or an extra done.

// File: rtl/cswitch_pkg.sv
package cswitch_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int OPC_W  = 8;
    localparam int STEP_W = 4;

    localparam logic [OPC_W-1:0] OPC_STORE   = 8'hF4;
    localparam logic [OPC_W-1:0] OPC_STACK   = 8'hF5;
    localparam logic [OPC_W-1:0] OPC_RESTORE = 8'hF6;
    localparam logic [OPC_W-1:0] OPC_SAVE    = 8'hF7;
    localparam logic [OPC_W-1:0] OPC_BRANCH  = 8'hF8;
    localparam logic [OPC_W-1:0] OPC_PRIO    = 8'hF9;
    localparam logic [OPC_W-1:0] OPC_JUMP    = 8'hFA;

    localparam logic [STEP_W-1:0] LEN_STORE   = 4'd9;
    localparam logic [STEP_W-1:0] LEN_STACK   = 4'd9;
    localparam logic [STEP_W-1:0] LEN_RESTORE = 4'd11;
    localparam logic [STEP_W-1:0] LEN_SAVE    = 4'd7;
    localparam logic [STEP_W-1:0] LEN_BRANCH  = 4'd12;
    localparam logic [STEP_W-1:0] LEN_PRIO    = 4'd11;
    localparam logic [STEP_W-1:0] LEN_JUMP    = 4'd7;

    typedef enum logic [2:0] {
        K_STORE, K_STACK, K_RESTORE, K_SAVE, K_BRANCH, K_PRIO, K_JUMP
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LO, S_HI, S_TAIL, S_FINAL
    } seq_state_e;

endpackage

// File: rtl/cs_decoder.sv
module cs_decoder
    import cswitch_pkg::*;
(
    input  logic [OPC_W-1:0]  op,
    output logic              legal,
    output op_kind_e          kind,
    output logic [STEP_W-1:0] len,
    output logic              rd_kind,
    output logic              wr_kind,
    output logic              addr_from_s2
);
    always_comb begin
        legal = 1'b1;
        kind  = K_PRIO;
        len   = LEN_PRIO;
        case (op)
            OPC_STORE:   begin kind = K_STORE;   len = LEN_STORE;   end
            OPC_STACK:   begin kind = K_STACK;   len = LEN_STACK;   end
            OPC_RESTORE: begin kind = K_RESTORE; len = LEN_RESTORE; end
            OPC_SAVE:    begin kind = K_SAVE;    len = LEN_SAVE;    end
            OPC_BRANCH:  begin kind = K_BRANCH;  len = LEN_BRANCH;  end
            OPC_PRIO:    begin kind = K_PRIO;    len = LEN_PRIO;    end
            OPC_JUMP:    begin kind = K_JUMP;    len = LEN_JUMP;    end
            default:     legal = 1'b0;
        endcase
    end

    assign rd_kind      = (kind == K_RESTORE) || (kind == K_BRANCH) || (kind == K_JUMP);
    assign wr_kind      = (kind == K_STORE) || (kind == K_STACK) || (kind == K_SAVE);
    assign addr_from_s2 = (kind == K_STORE) || (kind == K_STACK);
endmodule

// File: rtl/cs_step_counter.sv
module cs_step_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FIRST = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= FIRST;
        else if (run)   count <= count + FIRST;
    end
endmodule

// File: rtl/cs_arch_regs.sv
module cs_arch_regs
    import cswitch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_kind_e          kind,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic [WORD_W-1:0] sp,
    output logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] reg_a,
    output logic [WORD_W-1:0] reg_b
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp    <= '0;
            pc    <= '0;
            reg_a <= '0;
            reg_b <= '0;
        end else if (commit) begin
            case (kind)
                K_RESTORE: sp <= word;
                K_BRANCH:  pc <= (word == '0) ? pc + opb : pc + ONE;
                K_PRIO:    begin reg_a <= opa; reg_b <= opb; end
                K_JUMP:    pc <= word;
                default:   ;
            endcase
        end
    end

    a_r10_pc_only_on_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind != K_BRANCH && kind != K_JUMP) |=> $stable(pc));
    a_r8_prio_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == K_PRIO) |=> (reg_a == $past(opa) && reg_b == $past(opb)));
endmodule

// File: rtl/ctxsw_exec_unit.sv
module ctxsw_exec_unit
    import cswitch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [15:0]       src1,
    input  logic [15:0]       src2,
    output logic [15:0]       mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [15:0]       sp,
    output logic [15:0]       pc,
    output logic [15:0]       alu_a,
    output logic [15:0]       alu_b,
    output logic              done,
    output logic              illegal
);
    localparam logic [WORD_W-1:0] ONE_W = WORD_W'(1);
    localparam logic [WORD_W-1:0] TWO_W = WORD_W'(2);
    localparam logic [STEP_W-1:0] ONE_S = STEP_W'(1);

    seq_state_e state, state_nx;

    logic              dec_legal, dec_rd, dec_wr, dec_s2;
    op_kind_e          dec_kind;
    logic [STEP_W-1:0] dec_len;

    op_kind_e          kind_q;
    logic [STEP_W-1:0] len_q;
    logic              rd_q, wr_q, s2_q;
    logic [WORD_W-1:0] opa_q, opb_q;
    logic [BYTE_W-1:0] word_lo, word_hi;
    logic              hi_pend;
    logic [STEP_W-1:0] step_cnt;
    logic [WORD_W-1:0] base, wval;

    logic accept, launch, busy;

    cs_decoder u_dec (
        .op           (opcode),
        .legal        (dec_legal),
        .kind         (dec_kind),
        .len          (dec_len),
        .rd_kind      (dec_rd),
        .wr_kind      (dec_wr),
        .addr_from_s2 (dec_s2)
    );

    assign accept = start && (state == S_IDLE);
    assign launch = accept && dec_legal;
    assign busy   = (state != S_IDLE);

    cs_step_counter #(.CW(STEP_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .run   (busy),
        .count (step_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (launch) state_nx = (dec_rd || dec_wr) ? S_LO : S_TAIL;
            end
            S_LO:    state_nx = S_HI;
            S_HI:    state_nx = S_TAIL;
            S_TAIL: begin
                if (step_cnt == len_q - ONE_S) state_nx = S_FINAL;
            end
            S_FINAL: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // operand latch, illegal flag, read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_PRIO;
            len_q   <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            s2_q    <= 1'b0;
            opa_q   <= '0;
            opb_q   <= '0;
            word_lo <= '0;
            word_hi <= '0;
            hi_pend <= 1'b0;
            illegal <= 1'b0;
        end else begin
            illegal <= accept && !dec_legal;
            if (launch) begin
                kind_q <= dec_kind;
                len_q  <= dec_len;
                rd_q   <= dec_rd;
                wr_q   <= dec_wr;
                s2_q   <= dec_s2;
                opa_q  <= src1;
                opb_q  <= src2;
            end
            hi_pend <= (state == S_HI) && rd_q;
            if ((state == S_HI) && rd_q) word_lo <= mem_rdata;
            if (hi_pend)                 word_hi <= mem_rdata;
        end
    end

    // write value selection
    always_comb begin
        unique case (kind_q)
            K_STORE: wval = opa_q;
            K_STACK: wval = opa_q - TWO_W;
            K_SAVE:  wval = sp;
            default: wval = '0;
        endcase
    end

    assign base = s2_q ? opb_q : opa_q;

    // output logic
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_LO: begin
                mem_addr  = base;
                mem_rd    = rd_q;
                mem_wr    = wr_q;
                mem_wdata = wval[BYTE_W-1:0];
            end
            S_HI: begin
                mem_addr  = base + ONE_W;
                mem_rd    = rd_q;
                mem_wr    = wr_q;
                mem_wdata = wval[WORD_W-1:BYTE_W];
            end
            S_TAIL: ;
            S_FINAL: done = 1'b1;
            default: ;
        endcase
    end

    cs_arch_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (state == S_FINAL),
        .kind   (kind_q),
        .word   ({word_hi, word_lo}),
        .opa    (opa_q),
        .opb    (opb_q),
        .sp     (sp),
        .pc     (pc),
        .reg_a  (alu_a),
        .reg_b  (alu_b)
    );

    a_r13_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r2_done_at_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (step_cnt == len_q));
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(opa_q) && $stable(opb_q)));
    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_rd && !mem_wr && !done));
    a_r11_illegal_regs: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(sp) && $stable(pc) && $stable(alu_a) && $stable(alu_b)));
endmodule

// File: tb/tb_ctxsw_exec_unit.sv
module tb_ctxsw_exec_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] src1 = '0, src2 = '0;
    logic [15:0] mem_addr, sp, pc, alu_a, alu_b;
    logic        mem_rd, mem_wr, done, illegal;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem [0:255];
    logic        pl_en = 1'b0;
    logic [7:0]  pl_addr = '0, pl_data = '0;

    int checks = 0, errors = 0, cyc = 0;
    logic [15:0] m_sp = '0, m_pc = '0, m_a = '0, m_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxsw_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .src1(src1), .src2(src2), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sp(sp), .pc(pc), .alu_a(alu_a), .alu_b(alu_b),
        .done(done), .illegal(illegal)
    );

    always @(posedge clk) begin
        if (pl_en)  mem[pl_addr] <= pl_data;
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WDOG_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp < %0d", cyc, WDOG_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [7:0] op);
        case (op)
            8'hF4: return 9;  8'hF5: return 9;  8'hF6: return 11;
            8'hF7: return 7;  8'hF8: return 12; 8'hF9: return 11;
            8'hFA: return 7;  default: return 0;
        endcase
    endfunction

    task automatic poke_word(input logic [7:0] a, input logic [15:0] w);
        pl_en = 1'b1; pl_addr = a; pl_data = w[7:0];
        @(negedge clk);
        pl_addr = a + 8'd1; pl_data = w[15:8];
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    // run one legal opcode; word w is preloaded at the read address
    task automatic run_op(input logic [7:0] op, input logic [15:0] v1,
                          input logic [15:0] v2, input logic [15:0] w, input bit inject);
        int c;
        logic [15:0] wexp, base;
        bit is_rd, is_wr;
        is_rd = (op == 8'hF6) || (op == 8'hF8) || (op == 8'hFA);
        is_wr = (op == 8'hF4) || (op == 8'hF5) || (op == 8'hF7);
        base  = (op == 8'hF4 || op == 8'hF5) ? v2 : v1;
        if (is_rd) poke_word(v1[7:0], w);
        wexp = (op == 8'hF4) ? v1 : (op == 8'hF5) ? v1 - 16'd2 : m_sp;
        start = 1'b1; opcode = op; src1 = v1; src2 = v2;
        @(negedge clk);
        start = 1'b0;
        c = 1;
        // R13 / R3: step 1 access at base address
        chk("R13 step1 rd", {31'd0, mem_rd}, {31'd0, is_rd});
        chk("R3 step1 wr", {31'd0, mem_wr}, {31'd0, is_wr});
        if (is_rd || is_wr) chk("R3 step1 addr", {16'd0, mem_addr}, {16'd0, base});
        while (!done && c < 30) begin
            if (inject && c == 2) begin
                start = 1'b1; opcode = 8'hF9; src1 = 16'hDEAD; src2 = 16'hBEEF;
            end
            @(negedge clk);
            start = 1'b0;
            c++;
        end
        chk($sformatf("R2 len op %0h", op), c, exp_len(op));
        if (inject) begin
            start = 1'b1; opcode = 8'hF9; src1 = 16'hDEAD; src2 = 16'hBEEF;
        end
        @(negedge clk);
        start = 1'b0;
        case (op)
            8'hF6: m_sp = w;
            8'hF8: m_pc = (w == 16'd0) ? m_pc + v2 : m_pc + 16'd1;
            8'hF9: begin m_a = v1; m_b = v2; end
            8'hFA: m_pc = w;
            default: ;
        endcase
        chk("R6 sp", {16'd0, sp}, {16'd0, m_sp});
        chk("R7 R9 R10 pc", {16'd0, pc}, {16'd0, m_pc});
        chk("R8 R10 alu_a", {16'd0, alu_a}, {16'd0, m_a});
        chk("R8 R10 alu_b", {16'd0, alu_b}, {16'd0, m_b});
        if (is_wr)
            chk("R3 R4 R5 stored word", {16'd0, mem[base[7:0] + 8'd1], mem[base[7:0]]},
                {16'd0, wexp});
        if (inject) begin
            c = 0;
            repeat (13) begin
                if (done) c++;
                @(negedge clk);
            end
            chk("R12 no extra done", c, 0);
        end
    endtask

    task automatic run_illegal(input logic [7:0] op);
        int d;
        start = 1'b1; opcode = op; src1 = 16'h1234; src2 = 16'h0042;
        @(negedge clk);
        start = 1'b0;
        chk("R11 illegal pulse", {31'd0, illegal}, 32'd1);
        chk("R11 no access", {30'd0, mem_rd, mem_wr}, 32'd0);
        @(negedge clk);
        chk("R11 pulse one cycle", {31'd0, illegal}, 32'd0);
        d = 0;
        repeat (13) begin
            if (done || mem_wr || mem_rd) d++;
            @(negedge clk);
        end
        chk("R11 no activity", d, 0);
        chk("R11 regs kept", {sp, pc}, {m_sp, m_pc});
        chk("R11 alu kept", {alu_a, alu_b}, {m_a, m_b});
    endtask

    initial begin
        int seed;
        logic [7:0] rop;
        logic [15:0] r1, r2, rw;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 regs", {sp, pc}, 32'd0);
        chk("R1 alu", {alu_a, alu_b}, 32'd0);
        chk("R1 flags", {28'd0, done, illegal, mem_rd, mem_wr}, 32'd0);

        // directed corners
        run_op(8'hF6, 16'h0010, 16'h0000, 16'h1F80, 1'b0);   // R6
        run_op(8'hF7, 16'h0020, 16'h0000, 16'h0000, 1'b0);   // R5
        run_op(8'hF5, 16'h0001, 16'h0030, 16'h0000, 1'b0);   // R4 borrow -> FFFF
        run_op(8'hF4, 16'hA55A, 16'h0040, 16'h0000, 1'b0);   // R3
        run_op(8'hFA, 16'h0050, 16'h0000, 16'hFFF0, 1'b0);   // R9
        run_op(8'hF8, 16'h0060, 16'h0020, 16'h0000, 1'b0);   // R7 taken, wraps
        run_op(8'hF8, 16'h0060, 16'h0020, 16'h0100, 1'b0);   // R7 high byte nonzero
        run_op(8'hF8, 16'h0060, 16'h0020, 16'h0001, 1'b0);   // R7 low byte nonzero
        run_op(8'hF9, 16'h0007, 16'h0003, 16'h0000, 1'b1);   // R8, R12
        run_op(8'hF6, 16'h0070, 16'h0000, 16'h0C34, 1'b1);   // R12 on read op
        run_illegal(8'hF3);                                   // R11
        run_illegal(8'hFB);
        run_illegal(8'h00);

        // constrained random
        for (int i = 0; i < 60; i++) begin
            rop = 8'hF4 + 8'($urandom_range(0, 6));
            r1  = 16'($urandom);
            r2  = 16'($urandom);
            rw  = ($urandom_range(0, 1) == 0) ? 16'h0000 : 16'($urandom);
            if (rop != 8'hF4 && rop != 8'hF5 && rop != 8'hF9) r1 = 16'($urandom_range(0, 254));
            if (rop == 8'hF4 || rop == 8'hF5) r2 = 16'($urandom_range(0, 254));
            run_op(rop, r1, r2, rw, ($urandom_range(0, 3) == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule